// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This unit holds the interrupt enable register of a PC-style serial port and works out which interrupt to report. Four one-cycle event inputs come from the rest of the port: a receive line error (overrun, parity, framing or break), a received character, the transmit holding register going empty, and a change on a modem control line (CTS, DSR, ring or carrier detect). Each event sets its own pending latch. A latch stays set until the access that services it: a status register read, a receive buffer read, a transmit holding register write, or, for the transmit-empty cause, an identification read that reports it.

Software reaches the unit over a byte-wide register bus. At offset 1 it reads and writes the enable register, but only while the divisor-latch access bit is low. At offset 2 it reads the identification byte. That byte carries an active-low "interrupt pending" flag and a two-bit code for the most urgent enabled cause. The interrupt request output is high whenever any enabled cause is pending. Reads return data combinationally in the cycle the read strobe is high. Side effects of a read take hold at the clock edge that ends that cycle.

Top module: `uart_irq_prio`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable register reads 0x00, the identification byte reads 0x01, irq is low and no cause is pending.
- R2: A write to offset 1 with dlab low stores wdata[3:0] in the enable register. Bit 0 enables received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Reads at offset 1 return bits 7:4 as zero, and whatever is written to bits 7:4 has no effect.
- R3: With dlab high, a write to offset 1 leaves the enable register unchanged, and a read at offset 1 returns 0x00.
- R4: The identification byte reports only the most urgent enabled pending cause, in bits 2:1. The order from most to least urgent is: line status, code 11; received data, code 10; transmit empty, code 01; modem status, code 00.
- R5: Bit 0 of the identification byte is 0 exactly when irq is high. irq is high exactly when at least one pending cause has its enable bit set. With nothing reportable the byte is 0x01.
- R6: Bits 7:3 of the identification byte always read as zero.
- R7: An identification read that reports code 01 clears the transmit-empty latch. An identification read that reports any other cause clears nothing.
- R8: A read of the line status register clears the line-status latch. A read of the receive buffer clears the received-data latch. A read of the modem status register clears the modem latch. A write of the transmit holding register clears the transmit-empty latch.
- R9: A write at offset 1 (dlab low) that takes enable bit 1 from 0 to 1 while thr_empty is high sets the transmit-empty latch. The same write does nothing to that latch if bit 1 was already set or if thr_empty is low.
- R10: When an event and the clear strobe for the same cause arrive in the same cycle, the latch ends up set.
- R11: A cause that is pending while disabled stays latched. It is reported as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when no read or unmapped offset) |
| dlab | input | 1 | Divisor-latch access bit from the line control register |
| thr_empty | input | 1 | Level: transmit holding register is empty |
| ev_rls | input | 1 | Pulse: receive line error seen |
| ev_rda | input | 1 | Pulse: character received |
| ev_thre | input | 1 | Pulse: transmit holding register became empty |
| ev_msr | input | 1 | Pulse: modem control line changed |
| lsr_rd | input | 1 | Pulse: line status register read |
| rbr_rd | input | 1 | Pulse: receive buffer read |
| msr_rd | input | 1 | Pulse: modem status register read |
| thr_wr | input | 1 | Pulse: transmit holding register written |
| irq | output | 1 | Interrupt request |

## Verification
The case hardest to reach from the ports is an identification read while several causes are pending together. In that case the read must clear the transmit-empty latch only if that cause is the one shown, and must leave every other latch alone. The stimulus sweeps all sixteen pending patterns against all sixteen enable patterns. For each pair it resets, programs the enable register, pulses the chosen events and compares one identification read with a value computed from the priority order. Directed sequences then stack transmit-empty under line status to show that the lower cause survives a read and appears once the line status is serviced. They also cover the enable-bit re-arm, both with and without thr_empty.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NCAUSE = 4;
  // cause positions follow the enable register bit order
  localparam int C_RDA  = 0;
  localparam int C_THRE = 1;
  localparam int C_RLS  = 2;
  localparam int C_MSR  = 3;

  typedef logic [NCAUSE-1:0] cause_vec_t;

  // {code[1:0], none_pending}
  function automatic logic [2:0] iir_code(cause_vec_t act);
    logic [2:0] c;
    if (act[C_RLS])       c = 3'b110;
    else if (act[C_RDA])  c = 3'b100;
    else if (act[C_THRE]) c = 3'b010;
    else if (act[C_MSR])  c = 3'b000;
    else                  c = 3'b001;
    return c;
  endfunction
endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  cause_vec_t wbits,
  input  logic       thr_empty,
  output cause_vec_t ier_q,
  output logic       thre_arm
);
  // bit 1 rising under a write while the holding register is empty
  assign thre_arm = wr_sel & wbits[C_THRE] & ~ier_q[C_THRE] & thr_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)      ier_q <= '0;
    else if (wr_sel) ier_q <= wbits;
  end
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t set,
  input  cause_vec_t clr,
  output cause_vec_t pend_q
);
  for (genvar g = 0; g < NCAUSE; g++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rst_n)      pend_q[g] <= 1'b0;
      else if (set[g]) pend_q[g] <= 1'b1;
      else if (clr[g]) pend_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  cause_vec_t pend,
  input  cause_vec_t ena,
  output logic [2:0] code,
  output logic       any
);
  cause_vec_t act;
  assign act  = pend & ena;
  assign any  = |act;
  assign code = iir_code(act);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int IER_OFS = 1,
  parameter int IIR_OFS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dlab,
  input  logic              thr_empty,
  input  logic              ev_rls,
  input  logic              ev_rda,
  input  logic              ev_thre,
  input  logic              ev_msr,
  input  logic              lsr_rd,
  input  logic              rbr_rd,
  input  logic              msr_rd,
  input  logic              thr_wr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_OFS);
  localparam logic [ADDR_W-1:0] IIR_A = ADDR_W'(IIR_OFS);

  // named internal events
  logic       ier_sel, iir_sel, ier_wr, iir_rd, thre_seen_rd, thre_arm;
  cause_vec_t ier_q, pend_q, set_v, clr_v;
  logic [2:0] iir_val;
  logic       unused_hi;

  assign ier_sel      = (addr == IER_A) & ~dlab;
  assign iir_sel      = (addr == IIR_A);
  assign ier_wr       = wr_en & ier_sel;
  assign iir_rd       = rd_en & iir_sel;
  assign thre_seen_rd = iir_rd & (iir_val == 3'b010);
  assign unused_hi    = ^wdata[DATA_W-1:NCAUSE];

  uart_irq_ier_reg u_ier (
    .clk(clk), .rst_n(rst_n), .wr_sel(ier_wr), .wbits(wdata[NCAUSE-1:0]),
    .thr_empty(thr_empty), .ier_q(ier_q), .thre_arm(thre_arm)
  );

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[C_RLS]  = ev_rls;
    set_v[C_RDA]  = ev_rda;
    set_v[C_THRE] = ev_thre | thre_arm;
    set_v[C_MSR]  = ev_msr;
    clr_v[C_RLS]  = lsr_rd;
    clr_v[C_RDA]  = rbr_rd;
    clr_v[C_THRE] = thr_wr | thre_seen_rd;
    clr_v[C_MSR]  = msr_rd;
  end

  uart_irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend_q(pend_q)
  );

  uart_irq_encode u_enc (
    .pend(pend_q), .ena(ier_q), .code(iir_val), .any(irq)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (ier_sel)      rdata[NCAUSE-1:0] = ier_q;
      else if (iir_sel) rdata[2:0]        = iir_val;
    end
  end
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int IER_OFS = 1,
  parameter int IIR_OFS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              dlab,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              ev_rda,
  input logic              ev_thre,
  input logic [3:0]        ier_q,
  input logic [3:0]        pend_q,
  input logic [2:0]        iir_val
);
  localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_OFS);
  localparam logic [ADDR_W-1:0] IIR_A = ADDR_W'(IIR_OFS);

  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (ier_q == 4'h0 && pend_q == 4'h0));

  // R2
  ier_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IER_A && !dlab) |-> rdata[DATA_W-1:4] == '0);

  // R3
  dlab_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IER_A && dlab) |=> $stable(ier_q));

  // R4
  rls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[2] && ier_q[2]) |-> iir_val == 3'b110);

  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IIR_A) |-> rdata[0] == !irq);

  // R6
  iir_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IIR_A) |-> rdata[DATA_W-1:3] == '0);

  // R7
  thre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IIR_A && rdata[2:0] == 3'b010 && !ev_thre) |=> !pend_q[1]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rda |=> pend_q[0]);
endmodule

bind uart_irq_prio uart_irq_prio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IER_OFS(IER_OFS), .IIR_OFS(IIR_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .dlab(dlab), .rdata(rdata), .irq(irq), .ev_rda(ev_rda), .ev_thre(ev_thre),
  .ier_q(ier_q), .pend_q(pend_q), .iir_val(iir_val)
);

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, dlab = 1'b0, thr_empty = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_rls = 0, ev_rda = 0, ev_thre = 0, ev_msr = 0;
  logic       lsr_rd = 0, rbr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic       irq;
  int tests = 0, fails = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  uart_irq_prio dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .dlab(dlab), .thr_empty(thr_empty),
    .ev_rls(ev_rls), .ev_rda(ev_rda), .ev_thre(ev_thre), .ev_msr(ev_msr),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // expected byte: walk the causes from most to least urgent
  function automatic logic [7:0] exp_iir(input logic [3:0] p, input logic [3:0] en);
    int order [4] = '{2, 0, 1, 3};
    logic [3:0] a = p & en;
    for (int k = 0; k < 4; k++)
      if (a[order[k]]) return 8'((3 - k) << 1);
    return 8'h01;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // ev bits: {msr, rls, thre, rda}; cl bits: {msr_rd, lsr_rd, thr_wr, rbr_rd}
  task automatic pulse(input logic [3:0] ev, input logic [3:0] cl);
    @(negedge clk);
    {ev_msr, ev_rls, ev_thre, ev_rda} = ev;
    {msr_rd, lsr_rd, thr_wr, rbr_rd}  = cl;
    @(negedge clk);
    {ev_msr, ev_rls, ev_thre, ev_rda} = '0;
    {msr_rd, lsr_rd, thr_wr, rbr_rd}  = '0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    rd(3'd1, d); chk("R1 ier", d, 8'h00);
    rd(3'd2, d); chk("R1 iir", d, 8'h01);
    #1 chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2
    wr(3'd1, 8'hF0); rd(3'd1, d); chk("R2 hi ignored", d, 8'h00);
    wr(3'd1, 8'hA5); rd(3'd1, d); chk("R2 readback", d, 8'h05);

    // R3
    dlab = 1'b1;
    wr(3'd1, 8'h0A); rd(3'd1, d); chk("R3 read blocked", d, 8'h00);
    dlab = 1'b0;
    rd(3'd1, d); chk("R3 write blocked", d, 8'h05);

    // R4 R5 R6: sweep pending x enable
    for (int en = 0; en < 16; en++) begin
      for (int p = 0; p < 16; p++) begin
        do_reset();
        wr(3'd1, 8'(en));
        pulse(4'(p), 4'h0);
        #1 chk("R5 irq", {7'd0, irq}, {7'd0, |(4'(p) & 4'(en))});
        rd(3'd2, d); chk("R4 R6 iir", d, exp_iir(4'(p), 4'(en)));
      end
    end

    // R11
    do_reset();
    pulse(4'hF, 4'h0);
    rd(3'd2, d); chk("R11 masked", d, 8'h01);
    wr(3'd1, 8'h08); rd(3'd2, d); chk("R11 late enable", d, 8'h00);

    // R7
    do_reset();
    wr(3'd1, 8'h0F);
    pulse(4'b0010, 4'h0);
    rd(3'd2, d); chk("R7 report", d, 8'h02);
    rd(3'd2, d); chk("R7 cleared", d, 8'h01);
    pulse(4'b0110, 4'h0);
    rd(3'd2, d); chk("R7 rls first", d, 8'h06);
    rd(3'd2, d); chk("R7 no clear", d, 8'h06);
    pulse(4'h0, 4'b0100);
    rd(3'd2, d); chk("R7 thre kept", d, 8'h02);

    // R8
    do_reset();
    wr(3'd1, 8'h0F);
    pulse(4'b0001, 4'h0); rd(3'd2, d); chk("R8 rda set", d, 8'h04);
    pulse(4'h0, 4'b0001); rd(3'd2, d); chk("R8 rbr clr", d, 8'h01);
    pulse(4'b1000, 4'h0); rd(3'd2, d); chk("R8 msr set", d, 8'h00);
    pulse(4'h0, 4'b1000); rd(3'd2, d); chk("R8 msr clr", d, 8'h01);
    pulse(4'b0010, 4'h0); pulse(4'h0, 4'b0010);
    rd(3'd2, d); chk("R8 thr write clr", d, 8'h01);
    pulse(4'b0100, 4'h0); pulse(4'h0, 4'b0100);
    rd(3'd2, d); chk("R8 lsr clr", d, 8'h01);

    // R9
    do_reset();
    thr_empty = 1'b1;
    wr(3'd1, 8'h02); rd(3'd2, d); chk("R9 arm", d, 8'h02);
    rd(3'd2, d); chk("R9 read clr", d, 8'h01);
    wr(3'd1, 8'h02); rd(3'd2, d); chk("R9 no rearm when set", d, 8'h01);
    wr(3'd1, 8'h00); thr_empty = 1'b0;
    wr(3'd1, 8'h02); rd(3'd2, d); chk("R9 no arm when full", d, 8'h01);

    // R10
    do_reset();
    wr(3'd1, 8'h0F);
    pulse(4'b0001, 4'b0001); rd(3'd2, d); chk("R10 set wins", d, 8'h04);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule